// File: doc/BRIEF.md
# ADC Trigger Source Control Register

This block is a 16-bit memory-mapped control register that decides what starts a conversion on a paced ADC. Software writes a two-bit source selector and a set of mode enables. The block then produces a single-cycle `conv_start` pulse from one of two paths. The first is a software strobe. The second is the pacer tick, which only counts once an external digital trigger has fired. The mode enables for burst, pre-trigger, arm, FIFO mode and the counter-0 source are passed straight out to neighbouring logic.

The external trigger passes through a two-flop synchroniser and a rising-edge detector. It feeds a one-shot latch built as a two-state machine. In `XT_WAIT` the latch waits. The transition `ARM_HIT` moves it to `XT_FIRED` on a qualified rising edge, meaning the source is external and the external enable is set. In `XT_FIRED` every later edge is ignored. The transition `SW_CLEAR` returns it to `XT_WAIT` when software writes a one to the clear bit. Nothing else leaves `XT_FIRED`. While in `XT_FIRED` with the external source selected, each pacer tick becomes a conversion start. Selecting the disabled source stops all conversion starts, so the pacer can be programmed safely.

Top module: `adc_trig_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every stored control bit, the trigger latch and `conv_start`, so `rdata` reads 0x0000 afterwards.
- R2: A write stores bits [1:0] (source), bit 4 (external enable), bit 5 (burst), bit 6 (pre-trigger), bit 11 (arm), bit 12 (FIFO mode) and bit 13 (counter-0 source). Reserved bits read as 0, and bit 7 reads the trigger latch status. Writing 0xFFFF with the latch clear reads back 0x3873.
- R3: `burst_en`, `pretrig_en`, `arm_en`, `fifo_mode` and `cnt0_src` follow stored bits 5, 6, 11, 12 and 13 from the cycle after the write.
- R4: With source 01 (software), each cycle in which `sw_trig` is high gives exactly one `conv_start` pulse, one cycle later.
- R5: With source 00, 10 or 11, `sw_trig` has no effect on `conv_start`.
- R6: With source 10 and bit 4 set, a rising edge on `ext_trig` sets the latch. The flag is first high after the third clock edge that samples the new high level. With any other source, or with bit 4 clear, the edge leaves the flag low.
- R7: Once the latch is set, further `ext_trig` edges change nothing, and the flag stays high until it is cleared.
- R8: Writing 1 to bit 7 clears the latch. Writing 0 to bit 7 has no effect. When a clear write and a qualified edge fall in the same cycle, the clear wins and the latch stays low.
- R9: With source 10 and the latch set, each `pacer_tick` cycle gives one `conv_start` pulse one cycle later. With the latch clear, pacer ticks are ignored.
- R10: With source 00 or 11, `conv_start` never pulses.
- R11: An input already high when the enable is written is not an edge. The qualification uses the register value held before the write cycle.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data: stored bits plus latch status in bit 7 |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external digital trigger |
| pacer_tick | input | 1 | Pacer timing tick |
| conv_start | output | 1 | Conversion-start pulse |
| xtrig_flag | output | 1 | External trigger latch status |
| burst_en | output | 1 | Burst mode enable |
| pretrig_en | output | 1 | Pre-trigger mode enable |
| arm_en | output | 1 | Arm bit |
| fifo_mode | output | 1 | FIFO mode bit |
| cnt0_src | output | 1 | Counter-0 source select |

## Verification
Two events can coincide in one cycle: a clear write to bit 7, and a synchronised external edge that would set the latch. The bench lines them up on purpose. It drives `ext_trig` high, lets two clock edges pass, and then presents the clear write so that it lands on the detector's edge cycle. The expected outcome is a latch that stays low and a pacer tick that then yields no conversion. A second coincidence is a write that turns on the enable while the input is already high. The bench expects no latch from that.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_SOFT = 2'b01,
        SRC_EXT  = 2'b10,
        SRC_RSVD = 2'b11
    } trig_src_e;

    typedef enum logic {
        XT_WAIT  = 1'b0,
        XT_FIRED = 1'b1
    } xt_state_e;

    localparam int unsigned B_SRC_LO  = 0;
    localparam int unsigned B_SRC_HI  = 1;
    localparam int unsigned B_EXT_EN  = 4;
    localparam int unsigned B_BURST   = 5;
    localparam int unsigned B_PRETRIG = 6;
    localparam int unsigned B_CLEAR   = 7;
    localparam int unsigned B_ARM     = 11;
    localparam int unsigned B_FIFO    = 12;
    localparam int unsigned B_CNT0    = 13;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg
    import adc_trig_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output trig_src_e         src,
    output logic              ext_en,
    output logic              burst,
    output logic              pretrig,
    output logic              arm,
    output logic              ffm,
    output logic              c0sel,
    output logic              clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src     <= SRC_OFF;
            ext_en  <= 1'b0;
            burst   <= 1'b0;
            pretrig <= 1'b0;
            arm     <= 1'b0;
            ffm     <= 1'b0;
            c0sel   <= 1'b0;
        end else if (wr_en) begin
            src     <= trig_src_e'(wdata[B_SRC_HI:B_SRC_LO]);
            ext_en  <= wdata[B_EXT_EN];
            burst   <= wdata[B_BURST];
            pretrig <= wdata[B_PRETRIG];
            arm     <= wdata[B_ARM];
            ffm     <= wdata[B_FIFO];
            c0sel   <= wdata[B_CNT0];
        end
    end

    assign clr_req = wr_en & wdata[B_CLEAR];
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      ext_en,
    input  logic      rise,
    input  logic      clr_req,
    input  logic      sw_trig,
    input  logic      pacer_tick,
    output logic      fired,
    output logic      conv_start
);
    xt_state_e state, state_nx;
    logic      arm_hit;
    logic      conv_nx;

    assign arm_hit = rise && (src == SRC_EXT) && ext_en;

    always_comb begin
        state_nx = state;
        unique case (state)
            XT_WAIT:  if (arm_hit && !clr_req) state_nx = XT_FIRED;
            XT_FIRED: if (clr_req)             state_nx = XT_WAIT;
            default:                           state_nx = XT_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= XT_WAIT;
        else     state <= state_nx;
    end

    always_comb begin
        conv_nx = 1'b0;
        unique case (src)
            SRC_SOFT: conv_nx = sw_trig;
            SRC_EXT:  conv_nx = (state == XT_FIRED) && pacer_tick;
            default:  conv_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) conv_start <= 1'b0;
        else     conv_start <= conv_nx;
    end

    assign fired = (state == XT_FIRED);
endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
    import adc_trig_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sw_trig,
    input  logic              ext_trig,
    input  logic              pacer_tick,
    output logic              conv_start,
    output logic              xtrig_flag,
    output logic              burst_en,
    output logic              pretrig_en,
    output logic              arm_en,
    output logic              fifo_mode,
    output logic              cnt0_src
);
    trig_src_e src;
    logic      ext_en;
    logic      clr_req;
    logic      rise;

    trig_ctrl_reg #(.DATA_W(DATA_W)) i_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .src     (src),
        .ext_en  (ext_en),
        .burst   (burst_en),
        .pretrig (pretrig_en),
        .arm     (arm_en),
        .ffm     (fifo_mode),
        .c0sel   (cnt0_src),
        .clr_req (clr_req)
    );

    trig_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_trig),
        .rise (rise)
    );

    trig_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .ext_en     (ext_en),
        .rise       (rise),
        .clr_req    (clr_req),
        .sw_trig    (sw_trig),
        .pacer_tick (pacer_tick),
        .fired      (xtrig_flag),
        .conv_start (conv_start)
    );

    always_comb begin
        rdata                       = '0;
        rdata[B_SRC_HI:B_SRC_LO]    = src;
        rdata[B_EXT_EN]             = ext_en;
        rdata[B_BURST]              = burst_en;
        rdata[B_PRETRIG]            = pretrig_en;
        rdata[B_CLEAR]              = xtrig_flag;
        rdata[B_ARM]                = arm_en;
        rdata[B_FIFO]               = fifo_mode;
        rdata[B_CNT0]               = cnt0_src;
    end
endmodule

// File: rtl/adc_trig_ctl_chk.sv
module adc_trig_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        sw_trig,
    input logic        xtrig_flag,
    input logic        conv_start
);
    localparam logic [15:0] RSVD_MASK = 16'hC70C;

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rdata & RSVD_MASK) == 16'h0000);

    p_soft_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (rdata[1:0] == 2'b01) && sw_trig |=> conv_start);

    p_fire_qualified_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(xtrig_flag) |-> ($past(rdata[1:0]) == 2'b10) && $past(rdata[4]));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        xtrig_flag && !(wr_en && wdata[7]) |=> xtrig_flag);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en && wdata[7] |=> !xtrig_flag);

    p_source_off_r10: assert property (@(posedge clk) disable iff (rst)
        (rdata[1:0] == 2'b00) || (rdata[1:0] == 2'b11) |=> !conv_start);
endmodule

bind adc_trig_ctl adc_trig_ctl_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .sw_trig    (sw_trig),
    .xtrig_flag (xtrig_flag),
    .conv_start (conv_start)
);

// File: tb/test_adc_trig_ctl.sv
`timescale 1ns/1ps
module test_adc_trig_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sw_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic        pacer_tick = 1'b0;
    logic        conv_start, xtrig_flag, burst_en, pretrig_en, arm_en, fifo_mode, cnt0_src;

    int n_checks = 0;
    int n_fail   = 0;
    int n_conv   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    adc_trig_ctl i_adc_trig_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .sw_trig(sw_trig), .ext_trig(ext_trig), .pacer_tick(pacer_tick),
        .conv_start(conv_start), .xtrig_flag(xtrig_flag), .burst_en(burst_en),
        .pretrig_en(pretrig_en), .arm_en(arm_en), .fifo_mode(fifo_mode), .cnt0_src(cnt0_src)
    );

    // Behavioural reference
    int        m_src, m_ext_en, m_burst, m_pre, m_arm, m_ffm, m_c0;
    bit        m_flag, m_conv;
    bit        hist[$];

    function automatic void model_reset();
        m_src = 0; m_ext_en = 0; m_burst = 0; m_pre = 0; m_arm = 0; m_ffm = 0; m_c0 = 0;
        m_flag = 0; m_conv = 0;
        hist = '{1'b0, 1'b0, 1'b0};
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit edge_seen, clr, nflag, nconv;
            edge_seen = hist[hist.size()-2] && !hist[hist.size()-3];
            clr   = wr_en && wdata[7];
            nflag = m_flag;
            if (m_flag && clr) nflag = 0;
            if (!m_flag && edge_seen && m_src == 2 && m_ext_en == 1 && !clr) nflag = 1;
            nconv = (m_src == 1 && sw_trig) || (m_src == 2 && m_flag && pacer_tick);
            if (wr_en) begin
                m_src = wdata[1:0]; m_ext_en = wdata[4]; m_burst = wdata[5];
                m_pre = wdata[6]; m_arm = wdata[11]; m_ffm = wdata[12]; m_c0 = wdata[13];
            end
            m_flag = nflag;
            m_conv = nconv;
            hist.push_back(ext_trig);
            void'(hist.pop_front());
        end
    end

    function automatic int exp_rdata();
        return (m_src) | (m_ext_en << 4) | (m_burst << 5) | (m_pre << 6) | (int'(m_flag) << 7)
             | (m_arm << 11) | (m_ffm << 12) | (m_c0 << 13);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, expv, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(rdata == 16'(exp_rdata()), "R2 readback", rdata, exp_rdata());
            chk(xtrig_flag == m_flag, "R6 latch", xtrig_flag, m_flag);
            chk(conv_start == m_conv, "R9 conv_start", conv_start, m_conv);
            chk({cnt0_src, fifo_mode, arm_en, pretrig_en, burst_en} ==
                {m_c0[0], m_ffm[0], m_arm[0], m_pre[0], m_burst[0]}, "R3 modes",
                {cnt0_src, fifo_mode, arm_en, pretrig_en, burst_en},
                {m_c0[0], m_ffm[0], m_arm[0], m_pre[0], m_burst[0]});
            if (conv_start) n_conv++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic pulse_pacer();
        pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    endtask

    initial begin
        int c0;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk(rdata == 16'h0000, "R1 rdata after reset", rdata, 0);
        chk(!xtrig_flag && !conv_start, "R1 flag/conv after reset", {xtrig_flag, conv_start}, 0);

        // R2 write all ones
        wr(16'hFFFF);
        chk(rdata == 16'h3873, "R2 all-ones readback", rdata, 16'h3873);
        chk(burst_en && pretrig_en && arm_en && fifo_mode && cnt0_src, "R3 all modes on",
            {cnt0_src, fifo_mode, arm_en, pretrig_en, burst_en}, 5'h1F);
        // R10 source 11: no starts
        c0 = n_conv; pulse_sw(); pulse_pacer(); step(2);
        chk(n_conv == c0, "R10 source 11 silent", n_conv - c0, 0);

        // R3 single mode
        wr(16'h0020);
        chk(burst_en && !pretrig_en && !arm_en && !fifo_mode && !cnt0_src, "R3 burst only",
            {cnt0_src, fifo_mode, arm_en, pretrig_en, burst_en}, 5'h01);

        // R4 software trigger
        wr(16'h0001);
        c0 = n_conv; pulse_sw(); step(3);
        chk(n_conv - c0 == 1, "R4 one pulse per strobe", n_conv - c0, 1);
        c0 = n_conv; pulse_sw(); step(1); pulse_sw(); step(3);
        chk(n_conv - c0 == 2, "R4 two strobes", n_conv - c0, 2);

        // R5 / R10 source 00
        wr(16'h0010);
        c0 = n_conv; pulse_sw(); step(3);
        chk(n_conv == c0, "R5 strobe ignored at 00", n_conv - c0, 0);
        ext_trig = 1'b1; step(5); ext_trig = 1'b0; step(3);
        chk(!xtrig_flag, "R6 edge ignored at source 00", xtrig_flag, 0);

        // R6 enable clear
        wr(16'h0002);
        ext_trig = 1'b1; step(5); ext_trig = 1'b0; step(3);
        chk(!xtrig_flag, "R6 edge ignored with enable off", xtrig_flag, 0);
        c0 = n_conv; pulse_sw(); step(3);
        chk(n_conv == c0, "R5 strobe ignored at 10", n_conv - c0, 0);

        // R11 level already high when enabling
        ext_trig = 1'b1; step(4);
        wr(16'h0012); step(4);
        chk(!xtrig_flag, "R11 held level not an edge", xtrig_flag, 0);
        ext_trig = 1'b0; step(4);

        // R6 timing: high driven, flag after third edge
        ext_trig = 1'b1;
        step(2);
        chk(!xtrig_flag, "R6 flag not yet after two edges", xtrig_flag, 0);
        step(1);
        chk(xtrig_flag, "R6 flag after third edge", xtrig_flag, 1);

        // R9 pacer passes through
        c0 = n_conv; pulse_pacer(); step(2);
        chk(n_conv - c0 == 1, "R9 pacer to start", n_conv - c0, 1);

        // R7 further edges ignored
        ext_trig = 1'b0; step(3); ext_trig = 1'b1; step(4);
        chk(xtrig_flag, "R7 latch holds", xtrig_flag, 1);

        // R8 writing 0 in bit 7 no effect
        wr(16'h0012); step(1);
        chk(xtrig_flag, "R8 zero write keeps latch", xtrig_flag, 1);
        // R8 clear
        wr(16'h0092);
        chk(!xtrig_flag, "R8 clear write", xtrig_flag, 0);
        c0 = n_conv; pulse_pacer(); step(2);
        chk(n_conv == c0, "R9 pacer ignored when clear", n_conv - c0, 0);

        // R8 clear coinciding with qualified edge
        ext_trig = 1'b0; step(4);
        ext_trig = 1'b1;
        step(2);
        wr(16'h0092);
        step(3);
        chk(!xtrig_flag, "R8 clear beats coincident edge", xtrig_flag, 0);
        c0 = n_conv; pulse_pacer(); step(2);
        chk(n_conv == c0, "R9 no start after lost edge", n_conv - c0, 0);

        // Re-arm then reset mid-run
        ext_trig = 1'b0; step(4); ext_trig = 1'b1; step(4);
        chk(xtrig_flag, "R6 re-arm sets latch", xtrig_flag, 1);
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        chk(rdata == 16'h0000 && !xtrig_flag, "R1 reset clears latch", rdata, 0);
        ext_trig = 1'b0;
        step(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule